// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

This block adds two unsigned WIDTH-bit operands and a carry input through a chain of full-adder slots in which the carry travels between neighbours in alternating polarity. Slots at even positions take their operand bits and carry in true form and hand an inverted carry to the next slot. Slots at odd positions take complemented operand bits and that inverted carry, and by the full-adder inversion property they hand on a true carry. No inverter sits in the carry path between slots. Each slot derives its own generate, propagate and kill terms and writes sum and carry explicitly from them.

The sum bits are always returned in true form. Odd slots undo the inversion of their sum. When WIDTH is odd, the last carry in the chain is complemented, so it is corrected before it leaves the block. The adder itself is combinational. The result is captured in an output register that a synchronous active-high reset clears. The block serves as the plain carry-rippling datapath of a larger unit, where a fresh operand pair can be presented every cycle.

Top module: `alt_ripple_adder`

## Requirements
- R1: One clock edge after the operands are sampled, `sum_out` equals the low WIDTH bits of `op_a + op_b + carry_in`. A new operand set is accepted every cycle.
- R2: One clock edge after the operands are sampled, `carry_out` equals bit WIDTH of `op_a + op_b + carry_in`. It is in true polarity.
- R3: A clock edge with `rst` high sets `sum_out` and `carry_out` to zero, whatever the operands are.
- R4: When every bit position propagates (`op_a` XOR `op_b` all ones), `carry_out` equals the sampled `carry_in`. Every bit of `sum_out` equals the inverse of `carry_in`.
- R5: When every bit position kills (`op_a` and `op_b` both zero), `carry_out` is 0. `sum_out` is `carry_in` zero-extended to WIDTH bits.
- R6: When bit WIDTH-1 of both operands is 1, `carry_out` is 1.
- R7: When WIDTH is odd, the last slot sits at an even position, so its carry leaves the chain inverted. R1, R2 and R6 still hold. The check uses WIDTH = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First operand, unsigned |
| op_b | input | WIDTH | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Registered sum, true polarity |
| carry_out | output | 1 | Registered carry out of bit WIDTH-1, true polarity |

## Verification
Every result appears on the ports exactly one rising edge after its operands are driven. The only register in the path is the output register, and the carry chain settles within that same cycle. The bench drives operands on the falling edge and pushes the expected sum and carry into a queue at that moment. The monitor samples two nanoseconds after the next rising edge, so each queued item is compared against the result of the operands driven half a cycle earlier. A reset cycle works the same way: its queue entry expects zeros. Three widths run in lockstep: 4 bits and 5 bits (odd) are covered exhaustively, and 16 bits is covered with random, all-propagate, all-kill and top-generate patterns.

// File: rtl/alt_adder_pkg.sv
package alt_adder_pkg;

  // Polarity in which a slot receives its operands and carry
  typedef enum logic {
    SLOT_TRUE = 1'b0,
    SLOT_INV  = 1'b1
  } slot_pol_e;

  // Even positions work in true form, odd positions in complemented form
  function automatic slot_pol_e slot_polarity(input int pos);
    return (pos % 2 == 0) ? SLOT_TRUE : SLOT_INV;
  endfunction

endpackage

// File: rtl/fa_core_inv.sv
// Full-adder core: true sum, inverted carry, built from G / P / K terms
module fa_core_inv (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout_n
);
  logic gen, prop, kill;

  always_comb begin
    gen    = x & y;
    prop   = x ^ y;
    kill   = ~x & ~y;
    sum    = prop ^ cin;
    // carry is low when the slot kills, or when it neither generates nor receives
    cout_n = kill | (~gen & ~cin);
  end
endmodule

// File: rtl/fa_slot_even.sv
// Even slot: true operands and carry in, inverted carry out
module fa_slot_even (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co_n
);
  fa_core_inv u_core (
    .x      (a),
    .y      (b),
    .cin    (ci),
    .sum    (s),
    .cout_n (co_n)
  );
endmodule

// File: rtl/fa_slot_odd.sv
// Odd slot: complemented operands and carry in, true carry out.
// With all inputs inverted the core's sum is inverted, so it is re-inverted here.
module fa_slot_odd (
  input  logic a_n,
  input  logic b_n,
  input  logic ci_n,
  output logic s,
  output logic co
);
  logic s_inv;

  fa_core_inv u_core (
    .x      (a_n),
    .y      (b_n),
    .cin    (ci_n),
    .sum    (s_inv),
    .cout_n (co)
  );

  assign s = ~s_inv;
endmodule

// File: rtl/alt_carry_chain.sv
module alt_carry_chain
  import alt_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ci,
  output logic [WIDTH-1:0] s,
  output logic             co
);
  localparam slot_pol_e LAST_POL = slot_polarity(WIDTH - 1);

  // link[i] is the carry into slot i, in that slot's polarity
  logic [WIDTH:0] link;
  assign link[0] = ci;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slot
    if (slot_polarity(i) == SLOT_TRUE) begin : g_even
      fa_slot_even u_even (
        .a    (a[i]),
        .b    (b[i]),
        .ci   (link[i]),
        .s    (s[i]),
        .co_n (link[i+1])
      );
    end else begin : g_odd
      fa_slot_odd u_odd (
        .a_n  (~a[i]),
        .b_n  (~b[i]),
        .ci_n (link[i]),
        .s    (s[i]),
        .co   (link[i+1])
      );
    end
  end

  // An even last slot leaves the carry complemented
  if (LAST_POL == SLOT_TRUE) begin : g_fix_carry
    assign co = ~link[WIDTH];
  end else begin : g_pass_carry
    assign co = link[WIDTH];
  end
endmodule

// File: rtl/alt_ripple_adder.sv
module alt_ripple_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  logic [WIDTH-1:0] sum_comb;
  logic             carry_comb;

  alt_carry_chain #(
    .WIDTH (WIDTH)
  ) u_chain (
    .a  (op_a),
    .b  (op_b),
    .ci (carry_in),
    .s  (sum_comb),
    .co (carry_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      carry_out <= 1'b0;
    end else begin
      sum_out   <= sum_comb;
      carry_out <= carry_comb;
    end
  end
endmodule

// File: rtl/alt_ripple_adder_chk.sv
module alt_ripple_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_out,
  input logic             carry_out
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    seen && $past(rst) |-> (sum_out == '0) && !carry_out);

  // R1
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) |->
      sum_out == WIDTH'({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (WIDTH+1)'($past(carry_in))));

  // R2
  carry_value_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) |->
      carry_out == (({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + (WIDTH+1)'($past(carry_in))) >> WIDTH));

  // R4
  full_propagate_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && (($past(op_a) ^ $past(op_b)) == {WIDTH{1'b1}}) |->
      (carry_out == $past(carry_in)) && (sum_out == {WIDTH{~$past(carry_in)}}));

  // R5
  full_kill_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && (($past(op_a) | $past(op_b)) == '0) |->
      !carry_out && (sum_out == WIDTH'($past(carry_in))));

  // R6
  top_generate_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(op_a[WIDTH-1]) && $past(op_b[WIDTH-1]) |-> carry_out);
endmodule

bind alt_ripple_adder alt_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_a      (op_a),
  .op_b      (op_b),
  .carry_in  (carry_in),
  .sum_out   (sum_out),
  .carry_out (carry_out)
);

// File: tb/alt_ripple_adder_test.sv
module alt_ripple_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic        cin = 1'b0;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic [3:0]  a4 = '0, b4 = '0, s4;
  logic [4:0]  a5 = '0, b5 = '0, s5;
  logic        c16, c4, c5;

  alt_ripple_adder #(.WIDTH(16)) uut (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .carry_in(cin),
    .sum_out(s16), .carry_out(c16));
  alt_ripple_adder #(.WIDTH(4)) uut4 (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .carry_in(cin),
    .sum_out(s4), .carry_out(c4));
  alt_ripple_adder #(.WIDTH(5)) uut5 (
    .clk(clk), .rst(rst), .op_a(a5), .op_b(b5), .carry_in(cin),
    .sum_out(s5), .carry_out(c5));

  typedef struct {
    logic [16:0] e16;
    logic [4:0]  e4;
    logic [5:0]  e5;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(string req, string what, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: apply inputs on the falling edge and queue the expected result
  task automatic drive(logic r, logic ci, logic [15:0] x16, logic [15:0] y16,
                       logic [3:0] x4, logic [3:0] y4, logic [4:0] x5, logic [4:0] y5,
                       string tag);
    exp_t it;
    @(negedge clk);
    rst = r; cin = ci;
    a16 = x16; b16 = y16; a4 = x4; b4 = y4; a5 = x5; b5 = y5;
    if (r) begin
      it.e16 = '0; it.e4 = '0; it.e5 = '0; // R3
    end else begin
      it.e16 = 17'(x16) + 17'(y16) + 17'(ci);
      it.e4  = 5'(x4) + 5'(y4) + 5'(ci);
      it.e5  = 6'(x5) + 6'(y5) + 6'(ci);
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: results are due one rising edge after the drive; sample 2 ns later
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag == "R3" ? "R3" : "R1", "sum16", 17'(s16), 17'(it.e16[15:0]));
        check(it.tag == "R3" ? "R3" : "R2", "carry16", 17'(c16), 17'(it.e16[16]));
        check(it.tag, "sum4", 17'(s4), 17'(it.e4[3:0]));
        check(it.tag, "carry4", 17'(c4), 17'(it.e4[4]));
        check(it.tag == "R3" ? "R3" : "R7", "sum5", 17'(s5), 17'(it.e5[4:0]));
        check(it.tag == "R3" ? "R3" : "R7", "carry5", 17'(c5), 17'(it.e5[5]));
      end
    end
  end

  initial begin
    logic [15:0] r16;
    // R3: outputs clear while reset is held
    repeat (3) @(negedge clk);
    check("R3", "sum16 in reset", 17'(s16), 17'h0);
    check("R3", "carry16 in reset", 17'(c16), 17'h0);
    check("R3", "carry5 in reset", 17'(c5), 17'h0);

    // R1 R2 R7: exhaustive for 4 and 5 bits, random for 16 bits
    for (int i = 0; i < 2048; i++) begin
      logic [10:0] v;
      v = 11'(i);
      r16 = 16'($urandom);
      drive(1'b0, v[10], r16, 16'($urandom), v[3:0], v[7:4], v[4:0], v[9:5], "R1");
    end

    // R4: every position propagates
    for (int i = 0; i < 16; i++) begin
      r16 = 16'($urandom);
      drive(1'b0, i[0], r16, ~r16, r16[3:0], ~r16[3:0], r16[4:0], ~r16[4:0], "R4");
    end
    drive(1'b0, 1'b1, 16'h0000, 16'hFFFF, 4'h0, 4'hF, 5'h00, 5'h1F, "R4");

    // R5: every position kills
    drive(1'b0, 1'b0, 16'h0, 16'h0, 4'h0, 4'h0, 5'h0, 5'h0, "R5");
    drive(1'b0, 1'b1, 16'h0, 16'h0, 4'h0, 4'h0, 5'h0, 5'h0, "R5");

    // R6: top bit generates
    for (int i = 0; i < 16; i++) begin
      r16 = 16'($urandom);
      drive(1'b0, i[1], r16 | 16'h8000, 16'($urandom) | 16'h8000,
            r16[3:0] | 4'h8, 4'h8, r16[4:0] | 5'h10, 5'h10, "R6");
    end

    // R3: reset mid-stream with busy operands
    drive(1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 4'hF, 4'hF, 5'h1F, 5'h1F, "R3");
    drive(1'b0, 1'b1, 16'hFFFF, 16'h0001, 4'hF, 4'h1, 5'h1F, 5'h01, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule